// File: doc/BRIEF.md
# Bus Transfer Error Status Capture

This block records why bus cycles ended in error. Each time the bus side ends a cycle, it raises a termination strobe for one cycle. With the strobe it gives a flag telling an instruction fetch from a data access, and the cause of the error. The cause can be an externally driven error acknowledge, a bus-monitor timeout, or a parity failure on one or more byte lanes. The block turns these into sticky bits in a 32-bit status word. Software reads the word through a plain register port. It clears bits by writing ones to them.

There are two identical cause groups, one for fetches and one for data accesses. Each group holds an external-error bit, a timeout bit and one parity bit per byte lane. Parity results from memory outside the memory controller's control are kept only when a configuration input allows it. The block applies no exception-taken qualification, so a cancelled speculative access still leaves its mark. The block has no state machine: each status bit is an independent sticky flag, and there are no states or transitions.

Bit positions below use bit 0 as the least significant bit of the read word.

Top module: `xfer_err_status`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising edge), `reg_rdata` reads all zeros.
- R2: A status bit that is set stays set until reset, or until a write (`reg_wr` high) with a 1 in that bit position. A write with a 0 in a bit position leaves that bit unchanged.
- R3: A write with a 1 in a bit position clears that bit at the next rising edge, provided no event sets that bit in the same cycle.
- R4: Bits 31..14 and bits 7..6 always read 0, whatever is written to them.
- R5: A termination with `term_ext_err` high sets bit 13 when `term_is_fetch`=1 and bit 5 when `term_is_fetch`=0. It changes no bit of the other group.
- R6: A termination with `term_timeout` high sets bit 12 when `term_is_fetch`=1 and bit 4 when `term_is_fetch`=0.
- R7: A termination with `term_par_err[i]` high sets the parity bit for lane i only. That bit is 11-i for fetches and 3-i for data accesses, for i in 0..3.
- R8: When `term_unmanaged`=1 and `par_unmanaged_en`=0, parity inputs set no bit. When `term_unmanaged`=0, or when `par_unmanaged_en`=1, parity inputs are recorded.
- R9: While `term_valid` is low, the cause inputs set no bit.
- R10: If a termination sets a bit in the same cycle that a write clears it, the bit ends up set.
- R11: All causes present in one termination are recorded together, and bits set by later terminations add to those already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| term_valid | input | 1 | One-cycle strobe: a bus cycle ended, with the causes below |
| term_is_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| term_ext_err | input | 1 | The cycle ended with an externally driven error acknowledge |
| term_timeout | input | 1 | The cycle ended with a bus-monitor timeout |
| term_par_err | input | 4 | Parity failure per byte lane; bit i is lane i |
| term_unmanaged | input | 1 | The access targeted memory outside the memory controller |
| par_unmanaged_en | input | 1 | Configuration: record parity results for unmanaged memory |
| reg_wr | input | 1 | One-cycle write strobe of the register port |
| reg_wdata | input | 32 | Write data; each 1 clears the matching status bit |
| reg_rdata | output | 32 | Current status word |

## Verification
The main check sweeps every combination of access type, external error, timeout, the sixteen lane patterns, the unmanaged flag and the parity enable. Before each combination the status word is cleared. The bench computes the expected word arithmetically, so a wrong group, a swapped lane order or a wrong parity gate each give a different word. Further patterns cover several clear masks on a full word, including all-zero and reserved-only masks, which separate write-one-clear from write-zero and reserved handling. Other patterns are causes held with the strobe low, a set colliding with a clear, and events that accumulate across terminations.

// File: rtl/xfer_err_pkg.sv
package xfer_err_pkg;
    localparam int REG_W     = 32;
    localparam int LANES     = 4;
    localparam int GRP_W     = LANES + 2;
    localparam int DATA_LSB  = 0;
    localparam int FETCH_LSB = GRP_W + 2;
    localparam int N_GRP     = 2;

    typedef enum logic {
        ACC_DATA  = 1'b0,
        ACC_FETCH = 1'b1
    } acc_kind_e;

    function automatic logic [REG_W-1:0] live_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[DATA_LSB  +: GRP_W] = '1;
        m[FETCH_LSB +: GRP_W] = '1;
        return m;
    endfunction
endpackage

// File: rtl/xfer_err_group.sv
module xfer_err_group
    import xfer_err_pkg::*;
#(
    parameter int NLANE = LANES,
    localparam int GW   = NLANE + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             ext,
    input  logic             tmo,
    input  logic [NLANE-1:0] par,
    input  logic             par_ok,
    input  logic [GW-1:0]    clr,
    output logic [GW-1:0]    stat
);
    logic [GW-1:0] set_vec;

    always_comb begin
        set_vec        = '0;
        set_vec[GW-1]  = hit & ext;
        set_vec[GW-2]  = hit & tmo;
        for (int i = 0; i < NLANE; i++) begin
            set_vec[NLANE-1-i] = hit & par_ok & par[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            stat <= (stat & ~clr) | set_vec;
        end
    end

    // R10: a set in the same cycle as a clear leaves the bit set
    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (hit && ext && clr[GW-1]) |=> stat[GW-1]);

    // R9: nothing sets while the group is not hit
    p_no_hit_no_set_r9: assert property (@(posedge clk) disable iff (rst)
        (!hit) |=> ((stat & ~$past(stat)) == '0));

    // R7: each failing lane sets its own bit
    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_lane_chk
            p_lane_set_r7: assert property (@(posedge clk) disable iff (rst)
                (hit && par_ok && par[g]) |=> stat[NLANE-1-g]);
        end
    endgenerate
endmodule

// File: rtl/xfer_err_status.sv
module xfer_err_status
    import xfer_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             term_valid,
    input  logic             term_is_fetch,
    input  logic             term_ext_err,
    input  logic             term_timeout,
    input  logic [LANES-1:0] term_par_err,
    input  logic             term_unmanaged,
    input  logic             par_unmanaged_en,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata
);
    localparam logic [REG_W-1:0] LIVE = live_mask();

    acc_kind_e        kind;
    logic             par_ok;
    logic [REG_W-1:0] clr_word;
    logic [GRP_W-1:0] grp_stat [N_GRP];

    assign kind     = term_is_fetch ? ACC_FETCH : ACC_DATA;
    assign par_ok   = ~term_unmanaged | par_unmanaged_en;
    assign clr_word = reg_wr ? (reg_wdata & LIVE) : '0;

    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_grp
            localparam int        BASE = (g == 0) ? DATA_LSB : FETCH_LSB;
            localparam acc_kind_e MINE = (g == 0) ? ACC_DATA : ACC_FETCH;
            xfer_err_group #(.NLANE(LANES)) u_grp (
                .clk    (clk),
                .rst    (rst),
                .hit    (term_valid && (kind == MINE)),
                .ext    (term_ext_err),
                .tmo    (term_timeout),
                .par    (term_par_err),
                .par_ok (par_ok),
                .clr    (clr_word[BASE +: GRP_W]),
                .stat   (grp_stat[g])
            );
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        reg_rdata[DATA_LSB  +: GRP_W] = grp_stat[0];
        reg_rdata[FETCH_LSB +: GRP_W] = grp_stat[1];
    end

    // R4: reserved positions always read zero
    p_reserved_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~LIVE) == '0);

    // R2: a set bit survives unless a one was written to it
    p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(reg_rdata) & ~($past(reg_wr) ? $past(reg_wdata) : '0))
                   & ~reg_rdata) == '0));

    // R5: external error on a data access lands in the data group
    p_ext_data_r5: assert property (@(posedge clk) disable iff (rst)
        (term_valid && term_ext_err && !term_is_fetch) |=> reg_rdata[DATA_LSB + GRP_W - 1]);

    // R8: gated parity from unmanaged memory leaves the lane bits unchanged
    p_unmanaged_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (term_valid && term_unmanaged && !par_unmanaged_en && !reg_wr)
        |=> $stable(reg_rdata[DATA_LSB +: LANES]) && $stable(reg_rdata[FETCH_LSB +: LANES]));
endmodule

// File: tb/xfer_err_status_bench.sv
module xfer_err_status_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        term_valid, term_is_fetch, term_ext_err, term_timeout;
    logic [3:0]  term_par_err;
    logic        term_unmanaged, par_unmanaged_en;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    xfer_err_status u_xfer_err_status (
        .clk(clk), .rst(rst), .term_valid(term_valid), .term_is_fetch(term_is_fetch),
        .term_ext_err(term_ext_err), .term_timeout(term_timeout),
        .term_par_err(term_par_err), .term_unmanaged(term_unmanaged),
        .par_unmanaged_en(par_unmanaged_en), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [31:0] expect_word(input logic f, input logic e, input logic t,
                                                input logic [3:0] p, input logic u, input logic en);
        logic [31:0] w;
        logic [5:0]  grp;
        grp = {e, t, 4'b0};
        if (!u || en)
            for (int i = 0; i < 4; i++) grp[3-i] = p[i];
        w = 32'(grp);
        return f ? (w << 8) : w;
    endfunction

    task automatic check(input string req, input logic [31:0] exp);
        tests++;
        if (reg_rdata !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, reg_rdata, exp);
        end
    endtask

    task automatic idle();
        term_valid = 0; term_is_fetch = 0; term_ext_err = 0; term_timeout = 0;
        term_par_err = 0; term_unmanaged = 0; reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        idle();
    endtask

    task automatic event_in(input logic f, input logic e, input logic t, input logic [3:0] p,
                            input logic u);
        term_valid = 1; term_is_fetch = f; term_ext_err = e; term_timeout = t;
        term_par_err = p; term_unmanaged = u;
        tick();
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr = 1; reg_wdata = d;
        tick();
    endtask

    initial begin
        #(5ns * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle();
        par_unmanaged_en = 0;
        rst = 1;
        tick(); tick();
        rst = 0;
        check("R1 reset", 32'h0);

        // R5 R6 R7 R8: exhaustive sweep of one termination after a clear
        for (int k = 0; k < 512; k++) begin
            logic f, e, t, u, en;
            logic [3:0] p;
            {f, e, t, p, u, en} = 9'(k);
            wr(32'hFFFF_FFFF);
            par_unmanaged_en = en;
            event_in(f, e, t, p, u);
            check("R5/R6/R7/R8 sweep", expect_word(f, e, t, p, u, en));
        end
        par_unmanaged_en = 0;

        // R9: causes with strobe low
        wr(32'hFFFF_FFFF);
        term_is_fetch = 1; term_ext_err = 1; term_timeout = 1; term_par_err = 4'hF;
        tick();
        check("R9 strobe low", 32'h0);

        // R11: accumulate across terminations, several causes at once
        event_in(1, 1, 0, 4'b0001, 0);
        event_in(0, 0, 1, 4'b1000, 0);
        check("R11 accumulate", 32'h0000_2810 | 32'h1);
        event_in(1, 0, 1, 4'b0110, 0);
        check("R11 multi cause", 32'h0000_3E11);

        // R2: write of zero and reserved-only mask change nothing
        wr(32'h0);
        check("R2 write zero", 32'h0000_3E11);
        wr(32'hFFFF_C0C0);
        check("R4 reserved write", 32'h0000_3E11);

        // R3: partial clears
        wr(32'h0000_2001);
        check("R3 partial clear", 32'h0000_1E10);
        wr(32'h0000_1E10);
        check("R3 full clear", 32'h0);

        // R4: fill all live bits, reserved stay zero
        event_in(1, 1, 1, 4'hF, 0);
        event_in(0, 1, 1, 4'hF, 0);
        check("R4 reserved zero", 32'h0000_3F3F);

        // R10: set collides with clear
        wr(32'hFFFF_FFFF);
        reg_wr = 1; reg_wdata = 32'hFFFF_FFFF;
        term_valid = 1; term_is_fetch = 0; term_ext_err = 1; term_par_err = 4'b0100;
        tick();
        check("R10 set wins", 32'h0000_0022);

        // R8: managed memory ignores the enable
        wr(32'hFFFF_FFFF);
        event_in(1, 0, 0, 4'b1001, 0);
        check("R8 managed parity", 32'h0000_0900);

        // R1: reset clears a populated word
        rst = 1; tick(); rst = 0;
        check("R1 reset after use", 32'h0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule